// File: doc/BRIEF.md
# Mode-Dependent Multiplexed GPIO Port

This block is an eight-pin general-purpose I/O port on a simple memory-mapped register bus. Software sees three registers: a write-only direction register, a readable and writable output-data register, and a read-only register that returns the synchronized pin levels. Each pin drives an output-enable and an output value to its pad and receives an input level from it.

The operating-mode strap decides who owns each pin. In the single-chip mode (mode 7) every pin is plain GPIO. In the expanded modes (any other mode value, nominally 4 to 6) the top pin can carry the system clock, the next four pins always carry the external-bus strobes, and the low three pins can be claimed pin by pin by the bus controller for wait and arbitration signals. The bus controller and the clock generator are outside the block and appear only as input signals.

Hardware standby reloads the direction register with its mode-dependent reset value. Software standby keeps both registers. A hold-enable input then chooses whether the strobe pins keep their last levels or go high-impedance.

Top module: `modGpioPort`

## Requirements
- R1: After reset the direction register holds 0x80 when `opMode` is not 7 and 0x00 when `opMode` is 7, and the data register holds 0x00. This is observable on `padOe` and through the data-register read.
- R2: While `hwStandby` is high, each clock edge loads the direction register with its mode-dependent reset value. A direction write in the same cycle is discarded.
- R3: A read at the direction address (0xFE3E) always returns 0x00.
- R4: A write to the data address (0xFFBE) updates the data register at the clock edge where `busWr` is high. A read there returns the register contents, not the pin levels.
- R5: A read at the pin address (0xFF0E) returns `padIn` as sampled two clock edges earlier. Writes to that address change nothing. A read at any other address returns 0x00.
- R6: In mode 7, `padOe[i]` equals direction bit i and `padOut[i]` equals data bit i for all eight pins. The alternate-function inputs have no effect.
- R7: In expanded modes, pin 7 has `padOe[7]` equal to direction bit 7 and `padOut[7]` equal to `sysClk`.
- R8: In expanded modes, outside software standby, pins 6 to 3 are enabled whatever their direction bits are. `padOut[6:3]` equals `altStrobe[3:0]`, where bit 3 is the address strobe, bit 2 the read strobe, bit 1 the high-write strobe and bit 0 the low-write strobe.
- R9: In expanded modes, a pin i in 2..0 with `altEn[i]` high takes `altOe[i]` and `altOut[i]`. With `altEn[i]` low, it takes direction bit i and data bit i.
- R10: Software standby leaves the direction and data registers unchanged.
- R11: In expanded modes during software standby, pins 6 to 3 behave according to `busHoldEn`. When it is high they stay enabled and drive the `altStrobe` value from the last cycle before standby. When it is low their output-enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opMode | input | 3 | Operating-mode strap; 7 is single-chip, any other value is expanded |
| hwStandby | input | 1 | Hardware standby level |
| swStandby | input | 1 | Software standby level |
| busHoldEn | input | 1 | 1: strobe pins hold their levels in software standby; 0: they float |
| busAddr | input | 16 | Register bus address (low 16 bits) |
| busWr | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for `busAddr`, combinational |
| sysClk | input | 1 | System clock level for pin 7 |
| altStrobe | input | 4 | Bus strobes for pins 6..3 |
| altEn | input | 3 | Bus-controller ownership of pins 2..0 |
| altOut | input | 3 | Bus-controller output value for pins 2..0 |
| altOe | input | 3 | Bus-controller output enable for pins 2..0 |
| padIn | input | 8 | Pad input levels |
| padOut | output | 8 | Pad output values |
| padOe | output | 8 | Pad output enables |

## Verification
Two events can fall on the same clock edge: a direction-register write and the hardware-standby reload. The bench drives both for one edge with a value far from the reset pattern. It then checks that `padOe` shows the mode-dependent default and not the written value, in both the expanded mode and mode 7. A second coincidence is entry into software standby together with a change of the strobe inputs. The bench judges that case by checking that the held pins show the strobe value from the cycle before entry.

// File: rtl/gpioPortPkg.sv
package gpioPortPkg;
  localparam int PORT_W   = 8;
  localparam int CLK_PIN  = 7;
  localparam int STRB_LO  = 3;
  localparam int STRB_HI  = 6;
  localparam int STRB_W   = STRB_HI - STRB_LO + 1;
  localparam int ARB_W    = STRB_LO;
  localparam logic [2:0] SINGLE_CHIP_MODE = 3'd7;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_DIR,
    RD_DATA,
    RD_PINS
  } rdSel_e;

  typedef struct packed {
    logic   wrDir;
    logic   wrData;
    logic   loadDirDefault;
    logic   expanded;
    logic   busFloat;
    logic   busHold;
    rdSel_e rdSel;
  } ctrlStrb_t;
endpackage

// File: rtl/gpioPortCtrl.sv
module gpioPortCtrl
  import gpioPortPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 16'hFE3E,
  parameter logic [ADDR_W-1:0] PIN_ADDR  = 16'hFF0E,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFFBE,
  parameter logic [PORT_W-1:0] DIR_RST_EXPANDED = 8'h80,
  parameter logic [PORT_W-1:0] DIR_RST_SINGLE   = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        opMode,
  input  logic              hwStandby,
  input  logic              swStandby,
  input  logic              busHoldEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  output ctrlStrb_t         strb,
  output logic [PORT_W-1:0] dirDefault
);
  logic hitDir, hitData, hitPins, isExpanded;

  always_comb begin
    hitDir     = (busAddr == DIR_ADDR);
    hitData    = (busAddr == DATA_ADDR);
    hitPins    = (busAddr == PIN_ADDR);
    isExpanded = (opMode != SINGLE_CHIP_MODE);
    dirDefault = isExpanded ? DIR_RST_EXPANDED : DIR_RST_SINGLE;
  end

  always_comb begin
    strb                = '0;
    strb.expanded       = isExpanded;
    strb.loadDirDefault = hwStandby;
    strb.wrDir          = busWr && hitDir && !hwStandby;
    strb.wrData         = busWr && hitData;
    strb.busFloat       = isExpanded && swStandby && !busHoldEn;
    strb.busHold        = isExpanded && swStandby && busHoldEn;
    if (hitDir)       strb.rdSel = RD_DIR;
    else if (hitData) strb.rdSel = RD_DATA;
    else if (hitPins) strb.rdSel = RD_PINS;
    else              strb.rdSel = RD_NONE;
  end

  AST_NO_DIR_WRITE_IN_HWSTBY: assert property (@(posedge clk) disable iff (!rstN)
    hwStandby |-> !strb.wrDir); // R2

  AST_STBY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.busFloat && strb.busHold)); // R11
endmodule

// File: rtl/gpioPortDatapath.sv
module gpioPortDatapath
  import gpioPortPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [PORT_W-1:0] dirDefault,
  input  logic              swStandby,
  input  logic [PORT_W-1:0] busWrData,
  output logic [PORT_W-1:0] busRdData,
  input  logic              sysClk,
  input  logic [STRB_W-1:0] altStrobe,
  input  logic [ARB_W-1:0]  altEn,
  input  logic [ARB_W-1:0]  altOut,
  input  logic [ARB_W-1:0]  altOe,
  input  logic [PORT_W-1:0] padIn,
  output logic [PORT_W-1:0] padOut,
  output logic [PORT_W-1:0] padOe
);
  logic [PORT_W-1:0] dirQ;
  logic [PORT_W-1:0] dataQ;
  logic [STRB_W-1:0] strbHoldQ;
  logic [SYNC_STAGES-1:0][PORT_W-1:0] syncQ;
  logic [PORT_W-1:0] pinLevels;

  // Direction register: standby reload has priority over a bus write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    dirQ <= dirDefault;
    else if (strb.loadDirDefault) dirQ <= dirDefault;
    else if (strb.wrDir)          dirQ <= busWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            dataQ <= '0;
    else if (strb.wrData) dataQ <= busWrData;
  end

  // Last strobe levels seen before software standby
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           strbHoldQ <= '0;
    else if (!swStandby) strbHoldQ <= altStrobe;
  end

  // Input synchronizer chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= '0;
    else       syncQ[0] <= padIn;
  end
  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[s] <= '0;
      else       syncQ[s] <= syncQ[s-1];
    end
  end
  assign pinLevels = syncQ[SYNC_STAGES-1];

  always_comb begin
    unique case (strb.rdSel)
      RD_DATA: busRdData = dataQ;
      RD_PINS: busRdData = pinLevels;
      default: busRdData = '0;
    endcase
  end

  // Per-pin ownership mux
  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    if (i == CLK_PIN) begin : g_clk
      always_comb begin
        padOe[i]  = dirQ[i];
        padOut[i] = strb.expanded ? sysClk : dataQ[i];
      end
    end else if (i >= STRB_LO && i <= STRB_HI) begin : g_strobe
      always_comb begin
        if (!strb.expanded) begin
          padOe[i]  = dirQ[i];
          padOut[i] = dataQ[i];
        end else begin
          padOe[i]  = !strb.busFloat;
          padOut[i] = swStandby ? strbHoldQ[i-STRB_LO] : altStrobe[i-STRB_LO];
        end
      end
    end else begin : g_arb
      always_comb begin
        if (strb.expanded && altEn[i]) begin
          padOe[i]  = altOe[i];
          padOut[i] = altOut[i];
        end else begin
          padOe[i]  = dirQ[i];
          padOut[i] = dataQ[i];
        end
      end
    end
  end

  AST_DIR_DEFAULT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadDirDefault |=> dirQ == $past(dirDefault)); // R2

  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(rstN, 2)) |-> pinLevels == $past(padIn, 2)); // R5

  AST_SINGLE_CHIP_OE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.expanded |-> padOe == dirQ); // R6

  AST_STROBE_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.expanded && !swStandby) |-> padOe[STRB_HI:STRB_LO] == '1); // R8

  AST_STBY_RETAIN: assert property (@(posedge clk) disable iff (!rstN)
    (swStandby && !strb.loadDirDefault && !strb.wrDir) |=> $stable(dirQ)); // R10

  AST_BUS_FLOAT: assert property (@(posedge clk) disable iff (!rstN)
    strb.busFloat |-> padOe[STRB_HI:STRB_LO] == '0); // R11

  AST_HOLD_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(swStandby) && strb.busHold) |-> padOut[STRB_HI:STRB_LO] == $past(altStrobe)); // R11
endmodule

// File: rtl/modGpioPort.sv
module modGpioPort
  import gpioPortPkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 16'hFE3E,
  parameter logic [ADDR_W-1:0] PIN_ADDR  = 16'hFF0E,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFFBE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        opMode,
  input  logic              hwStandby,
  input  logic              swStandby,
  input  logic              busHoldEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  input  logic              sysClk,
  input  logic [3:0]        altStrobe,
  input  logic [2:0]        altEn,
  input  logic [2:0]        altOut,
  input  logic [2:0]        altOe,
  input  logic [7:0]        padIn,
  output logic [7:0]        padOut,
  output logic [7:0]        padOe
);
  ctrlStrb_t         strb;
  logic [PORT_W-1:0] dirDefault;

  gpioPortCtrl #(
    .ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR), .PIN_ADDR(PIN_ADDR), .DATA_ADDR(DATA_ADDR)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .opMode(opMode), .hwStandby(hwStandby),
    .swStandby(swStandby), .busHoldEn(busHoldEn), .busAddr(busAddr),
    .busWr(busWr), .strb(strb), .dirDefault(dirDefault)
  );

  gpioPortDatapath #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .dirDefault(dirDefault),
    .swStandby(swStandby), .busWrData(busWrData), .busRdData(busRdData),
    .sysClk(sysClk), .altStrobe(altStrobe), .altEn(altEn), .altOut(altOut),
    .altOe(altOe), .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  AST_DIR_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == DIR_ADDR) |-> busRdData == '0); // R3
endmodule

// File: tb/modGpioPort_tb.sv
module modGpioPort_tb_top;
  localparam logic [15:0] A_DIR  = 16'hFE3E;
  localparam logic [15:0] A_PIN  = 16'hFF0E;
  localparam logic [15:0] A_DATA = 16'hFFBE;

  logic clk = 0, rstN = 0;
  logic [2:0] opMode = 3'd5;
  logic hwStandby = 0, swStandby = 0, busHoldEn = 1;
  logic [15:0] busAddr = '0;
  logic busWr = 0;
  logic [7:0] busWrData = '0, busRdData;
  logic sysClk = 0;
  logic [3:0] altStrobe = '0;
  logic [2:0] altEn = '0, altOut = '0, altOe = '0;
  logic [7:0] padIn = '0, padOut, padOe;
  int nChecks = 0, nFail = 0;

  always #2 clk = ~clk;

  modGpioPort dut_i (
    .clk(clk), .rstN(rstN), .opMode(opMode), .hwStandby(hwStandby),
    .swStandby(swStandby), .busHoldEn(busHoldEn), .busAddr(busAddr),
    .busWr(busWr), .busWrData(busWrData), .busRdData(busRdData),
    .sysClk(sysClk), .altStrobe(altStrobe), .altEn(altEn), .altOut(altOut),
    .altOe(altOe), .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWrData = d; busWr = 1;
    @(posedge clk); @(negedge clk); busWr = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); busAddr = a; #1 d = busRdData;
  endtask

  task automatic doReset(input logic [2:0] m);
    @(negedge clk); rstN = 0; opMode = m;
    repeat (3) @(negedge clk); rstN = 1;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [7:0] r, eOe, eOut, dv;
    // R1: reset state in an expanded mode and in mode 7
    doReset(3'd5);
    #1 chk("R1 oe expanded", padOe, 8'hF8);
    rd(A_DATA, r); chk("R1 data reset", r, 8'h00);
    rd(A_DIR, r);  chk("R3 dir reads zero", r, 8'h00);
    doReset(3'd7);
    #1 chk("R1 oe mode7", padOe, 8'h00);

    // R6: mode 7 exhaustive direction sweep, alternate inputs toggled
    for (int v = 0; v < 256; v++) begin
      dv = 8'(v) ^ 8'h5A;
      wr(A_DIR, 8'(v)); wr(A_DATA, dv);
      altEn = 3'(v); altOe = 3'(~v); altOut = 3'(v >> 3); altStrobe = 4'(v); sysClk = v[0];
      #1 chk("R6 oe", padOe, 8'(v)); chk("R6 out", padOut, dv);
      rd(A_DATA, r); chk("R4 data read", r, dv);
      rd(A_DIR, r);  chk("R3 dir read", r, 8'h00);
    end

    // R7 R8 R9: expanded modes, sweep direction with alternate inputs
    for (int m = 4; m < 7; m++) begin
      opMode = 3'(m);
      for (int v = 0; v < 256; v++) begin
        dv = 8'(v * 37 + m);
        wr(A_DIR, 8'(v)); wr(A_DATA, dv);
        altEn = 3'(v >> 2); altOe = 3'(v >> 5); altOut = 3'(v + m);
        altStrobe = 4'(v >> 1); sysClk = v[4];
        eOe  = {v[7], 4'hF, 3'b000};
        eOut = {sysClk, altStrobe, 3'b000};
        for (int i = 0; i < 3; i++) begin
          eOe[i]  = altEn[i] ? altOe[i]  : v[i];
          eOut[i] = altEn[i] ? altOut[i] : dv[i];
        end
        #1 chk("R7 R8 R9 oe", padOe, eOe); chk("R7 R8 R9 out", padOut, eOut);
      end
    end
    altEn = '0;

    // R5: pin synchronizer latency, write ignored, unmapped read
    for (int p = 0; p < 8; p++) begin
      @(negedge clk); busAddr = A_PIN; padIn = 8'(8'h11 * (p + 1));
      @(posedge clk); @(negedge clk); #1 chk("R5 one edge old", busRdData, 8'(8'h11 * p));
      @(posedge clk); @(negedge clk); #1 chk("R5 two edges new", busRdData, padIn);
    end
    wr(A_DATA, 8'h96); wr(A_PIN, 8'h00);
    rd(A_PIN, r);  chk("R5 pin write ignored", r, padIn);
    rd(A_DATA, r); chk("R5 pin write leaves data", r, 8'h96);
    rd(16'h1234, r); chk("R5 unmapped read", r, 8'h00);

    // R2: hw standby reload coincides with a direction write
    opMode = 3'd5; wr(A_DIR, 8'h07);
    @(negedge clk); hwStandby = 1; busAddr = A_DIR; busWrData = 8'h3F; busWr = 1;
    @(posedge clk); @(negedge clk); busWr = 0;
    #1 chk("R2 reload expanded", padOe, 8'hF8);
    hwStandby = 0;
    opMode = 3'd7; wr(A_DIR, 8'hFF);
    @(negedge clk); hwStandby = 1; busWrData = 8'h3C; busWr = 1; busAddr = A_DIR;
    @(posedge clk); @(negedge clk); busWr = 0; hwStandby = 0;
    #1 chk("R2 reload mode7", padOe, 8'h00);

    // R10: software standby retains registers
    wr(A_DIR, 8'hA5); wr(A_DATA, 8'h3C);
    @(negedge clk); swStandby = 1;
    repeat (4) @(negedge clk);
    #1 chk("R10 dir kept", padOe, 8'hA5); chk("R10 data kept", padOut, 8'h3C);
    swStandby = 0;
    rd(A_DATA, r); chk("R10 data after", r, 8'h3C);

    // R11: hold and float of strobe pins on entry to software standby
    opMode = 3'd4; busHoldEn = 1;
    @(negedge clk); altStrobe = 4'hA;
    @(posedge clk); @(negedge clk); swStandby = 1; altStrobe = 4'h5;
    #1 chk("R11 hold level", {4'h0, padOut[6:3]}, 8'h0A);
    chk("R11 hold oe", {4'h0, padOe[6:3]}, 8'h0F);
    repeat (3) @(negedge clk);
    #1 chk("R11 hold persists", {4'h0, padOut[6:3]}, 8'h0A);
    busHoldEn = 0;
    #1 chk("R11 float oe", {4'h0, padOe[6:3]}, 8'h00);
    swStandby = 0; busHoldEn = 1;
    #1 chk("R8 after standby", {4'h0, padOut[6:3]}, 8'h05);

    finishRun();
  end
endmodule